// File: doc/BRIEF.md
# Serial Programming Instruction Interface

This block is the target side of a four-byte serial programming link. It works while the device is held in its programming reset. SCK, MOSI and the hold input arrive asynchronously. They are brought into the local clock domain through a synchronizer, and SCK edges are found by comparing successive synchronized samples. Data is captured MSB first on SCK rising edges. MISO changes only on SCK falling edges. During each byte, MISO returns the byte received just before it, so the host can confirm frame alignment. After the third byte of an instruction, a read value from the memory back end can be returned in its place.

The controller is a three-state machine. `ST_HOLD` is entered while the hold input is high. The transition *release* leads to `ST_LOCKED`. The transition *unlock* leads to `ST_ACTIVE`; it fires when a complete frame carries the enable pattern 0xAC, 0x53 in its first two bytes. The transition *hold* leads back to `ST_HOLD` from any state. In `ST_LOCKED`, frames are shifted and echoed but never handed on. In `ST_ACTIVE`, every completed frame is presented to the back end with a one-cycle strobe. A high pulse on the hold input is the recovery path after a loss of alignment.

Top module: `sprog_if`

## Requirements
- R1: While the synchronized hold input is high, MISO is 0, `cmd_valid` and `rd_req` stay low, the bit and byte counters are cleared, and the controller is in `ST_HOLD`.
- R2: MOSI is captured only on detected SCK rising edges, MSB first. Each eight bits form one byte, and four bytes form one frame: byte 0 is the opcode, byte 1 the address high, byte 2 the address low, and byte 3 the data.
- R3: MISO changes only after a detected SCK falling edge. Throughout the first byte of each frame, MISO is 0.
- R4: During the second and third bytes of a frame, MISO returns, MSB first, the byte received immediately before. While the controller is not in `ST_ACTIVE`, the fourth byte also returns the third byte. The key 0x53 therefore appears during the third byte of an enable frame.
- R5: In `ST_LOCKED`, no frame produces `cmd_valid`, and this includes the enable frame itself. A frame whose first two bytes are not 0xAC, 0x53 leaves the controller locked. All four bytes of that frame are still consumed.
- R6: In `ST_ACTIVE`, each completed frame raises `cmd_valid` for exactly one cycle. This happens in the cycle after the last rising edge is detected, with the four frame bytes on `cmd_op`, `cmd_addr_hi`, `cmd_addr_lo` and `cmd_data`.
- R7: In `ST_ACTIVE`, `rd_req` pulses once when the third byte completes. The fourth byte on MISO is then `rd_data`, captured at the next SCK falling edge.
- R8: A hold pulse in the middle of a frame discards the partial frame and restarts alignment at bit 0 of byte 0. It also returns the controller to locked, so a new enable frame is required.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local CPU clock |
| rst_n | input | 1 | Asynchronous active-low reset of all flops |
| prog_hold | input | 1 | Asynchronous hold; high clears framing and enable state |
| sck | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| rd_data | input | 8 | Read value from the back end, addressed by the captured bytes |
| rd_req | output | 1 | One-cycle strobe: opcode and address bytes of an active frame are complete |
| cmd_valid | output | 1 | One-cycle strobe: a full active frame is on the command outputs |
| cmd_op | output | 8 | Captured byte 0 |
| cmd_addr_hi | output | 8 | Captured byte 1 |
| cmd_addr_lo | output | 8 | Captured byte 2 |
| cmd_data | output | 8 | Captured byte 3 |

## Verification
The bench sends frames while the block is locked, and a near-miss enable frame whose key byte is 0x52. If the lock were missing or decoded loosely, commands would leak out before the enable and the scoreboard would see items it never queued. Every MISO bit is sampled just before each rising edge. An echo shifted by one bit, or a byte of echo lag, therefore shows up as a wrong byte. So does a read value that is loaded too late for the fourth byte. A hold pulse is applied two bytes into a frame, followed by a fresh enable frame. If the counters were not cleared, the 0x53 echo would be misaligned. If the enable survived the pulse, the next command would be delivered when it should be dropped.

// File: rtl/sprog_pkg.sv
package sprog_pkg;

    typedef enum logic [1:0] {
        ST_HOLD   = 2'd0,
        ST_LOCKED = 2'd1,
        ST_ACTIVE = 2'd2
    } sprog_state_e;

endpackage

// File: rtl/sprog_sampler.sv
module sprog_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_a,
    input  logic sck_a,
    input  logic mosi_a,
    output logic hold_s,
    output logic mosi_s,
    output logic sck_rise,
    output logic sck_fall
);
    localparam int LAST = SYNC_STAGES - 1;
    localparam logic [2:0] RST_VAL = 3'b100;   // {hold, mosi, sck}: hold asserted

    logic [2:0] stg_q [SYNC_STAGES];
    logic       sck_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SYNC_STAGES; i++) stg_q[i] <= RST_VAL;
            sck_prev_q <= 1'b0;
        end else begin
            stg_q[0] <= {hold_a, mosi_a, sck_a};
            for (int i = 1; i < SYNC_STAGES; i++) stg_q[i] <= stg_q[i-1];
            sck_prev_q <= stg_q[LAST][0];
        end
    end

    assign hold_s   = stg_q[LAST][2];
    assign mosi_s   = stg_q[LAST][1];
    assign sck_rise =  stg_q[LAST][0] & ~sck_prev_q;
    assign sck_fall = ~stg_q[LAST][0] &  sck_prev_q;

endmodule

// File: rtl/sprog_shifter.sv
module sprog_shifter #(
    parameter int BYTE_W      = 8,
    parameter int FRAME_BYTES = 4,
    localparam int BIT_W      = $clog2(BYTE_W),
    localparam int IDX_W      = $clog2(FRAME_BYTES)
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  clr,
    input  logic                                  rise,
    input  logic                                  fall,
    input  logic                                  mosi,
    input  logic                                  use_rd,
    input  logic [BYTE_W-1:0]                     rd_data,
    output logic                                  byte_done,
    output logic                                  frame_done,
    output logic [IDX_W-1:0]                      byte_idx,
    output logic [FRAME_BYTES-1:0][BYTE_W-1:0]    frame_q,
    output logic                                  miso
);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BYTE_W - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_BYTES - 1);

    logic [BIT_W-1:0]  bit_q;
    logic [IDX_W-1:0]  byte_q;
    logic [BYTE_W-2:0] rx_q;
    logic [BYTE_W-1:0] tx_q;
    logic [BYTE_W-1:0] tx_next;
    logic              pend_q;

    assign byte_done  = rise && (bit_q == BIT_LAST);
    assign frame_done = byte_done && (byte_q == IDX_LAST);
    assign byte_idx   = byte_q;
    assign miso       = tx_q[BYTE_W-1];

    // byte_q already points at the next byte when the load happens
    always_comb begin
        if (byte_q == '0)
            tx_next = '0;
        else if (byte_q == IDX_LAST && use_rd)
            tx_next = rd_data;
        else
            tx_next = frame_q[byte_q - 1'b1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q   <= '0;
            byte_q  <= '0;
            rx_q    <= '0;
            tx_q    <= '0;
            pend_q  <= 1'b0;
            frame_q <= '0;
        end else if (clr) begin
            bit_q  <= '0;
            byte_q <= '0;
            tx_q   <= '0;
            pend_q <= 1'b0;
        end else begin
            if (rise) begin
                rx_q  <= {rx_q[BYTE_W-3:0], mosi};
                bit_q <= (bit_q == BIT_LAST) ? '0 : bit_q + 1'b1;
                if (bit_q == BIT_LAST) begin
                    frame_q[byte_q] <= {rx_q, mosi};
                    byte_q          <= (byte_q == IDX_LAST) ? '0 : byte_q + 1'b1;
                    pend_q          <= 1'b1;
                end
            end
            if (fall) begin
                if (pend_q) begin
                    tx_q   <= tx_next;
                    pend_q <= 1'b0;
                end else begin
                    tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
                end
            end
        end
    end

endmodule

// File: rtl/sprog_ctrl.sv
module sprog_ctrl
    import sprog_pkg::*;
#(
    parameter int              BYTE_W  = 8,
    parameter int              IDX_W   = 2,
    parameter logic [IDX_W-1:0] RD_IDX = 2'd2,
    parameter logic [BYTE_W-1:0] EN_OP  = 8'hAC,
    parameter logic [BYTE_W-1:0] EN_KEY = 8'h53
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold_s,
    input  logic              byte_done,
    input  logic              frame_done,
    input  logic [IDX_W-1:0]  byte_idx,
    input  logic [BYTE_W-1:0] op_byte,
    input  logic [BYTE_W-1:0] key_byte,
    output sprog_state_e      state,
    output logic              use_rd,
    output logic              cmd_valid,
    output logic              rd_req
);
    sprog_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD:   if (!hold_s) state_d = ST_LOCKED;              // release
            ST_LOCKED: if (frame_done && op_byte == EN_OP && key_byte == EN_KEY)
                           state_d = ST_ACTIVE;                       // unlock
            ST_ACTIVE: state_d = ST_ACTIVE;
            default:   state_d = ST_HOLD;
        endcase
        if (hold_s) state_d = ST_HOLD;                                // hold
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_valid <= 1'b0;
            rd_req    <= 1'b0;
        end else begin
            cmd_valid <= !hold_s && state_q == ST_ACTIVE && frame_done;
            rd_req    <= !hold_s && state_q == ST_ACTIVE && byte_done && byte_idx == RD_IDX;
        end
    end

    assign state  = state_q;
    assign use_rd = (state_q == ST_ACTIVE);

endmodule

// File: rtl/sprog_if.sv
module sprog_if
    import sprog_pkg::*;
#(
    parameter int                BYTE_W      = 8,
    parameter int                FRAME_BYTES = 4,
    parameter int                SYNC_STAGES = 2,
    parameter logic [BYTE_W-1:0] EN_OP       = 8'hAC,
    parameter logic [BYTE_W-1:0] EN_KEY      = 8'h53
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_hold,
    input  logic              sck,
    input  logic              mosi,
    output logic              miso,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              rd_req,
    output logic              cmd_valid,
    output logic [BYTE_W-1:0] cmd_op,
    output logic [BYTE_W-1:0] cmd_addr_hi,
    output logic [BYTE_W-1:0] cmd_addr_lo,
    output logic [BYTE_W-1:0] cmd_data
);
    localparam int IDX_W = $clog2(FRAME_BYTES);
    localparam logic [IDX_W-1:0] RD_IDX = IDX_W'(FRAME_BYTES - 2);

    logic                               hold_s, mosi_s, sck_rise, sck_fall;
    logic                               byte_done, frame_done, use_rd;
    logic [IDX_W-1:0]                   byte_idx;
    logic [FRAME_BYTES-1:0][BYTE_W-1:0] frame_q;
    sprog_state_e                       state;

    sprog_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
        .clk(clk), .rst_n(rst_n),
        .hold_a(prog_hold), .sck_a(sck), .mosi_a(mosi),
        .hold_s(hold_s), .mosi_s(mosi_s),
        .sck_rise(sck_rise), .sck_fall(sck_fall)
    );

    sprog_shifter #(.BYTE_W(BYTE_W), .FRAME_BYTES(FRAME_BYTES)) u_shifter (
        .clk(clk), .rst_n(rst_n), .clr(hold_s),
        .rise(sck_rise), .fall(sck_fall), .mosi(mosi_s),
        .use_rd(use_rd), .rd_data(rd_data),
        .byte_done(byte_done), .frame_done(frame_done),
        .byte_idx(byte_idx), .frame_q(frame_q), .miso(miso)
    );

    sprog_ctrl #(
        .BYTE_W(BYTE_W), .IDX_W(IDX_W), .RD_IDX(RD_IDX),
        .EN_OP(EN_OP), .EN_KEY(EN_KEY)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .hold_s(hold_s),
        .byte_done(byte_done), .frame_done(frame_done), .byte_idx(byte_idx),
        .op_byte(frame_q[0]), .key_byte(frame_q[1]),
        .state(state), .use_rd(use_rd),
        .cmd_valid(cmd_valid), .rd_req(rd_req)
    );

    assign cmd_op      = frame_q[0];
    assign cmd_addr_hi = frame_q[1];
    assign cmd_addr_lo = frame_q[2];
    assign cmd_data    = frame_q[FRAME_BYTES-1];

endmodule

// File: rtl/sprog_chk.sv
module sprog_chk
    import sprog_pkg::*;
#(
    parameter int IDX_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hold_s,
    input logic             sck_rise,
    input logic             sck_fall,
    input logic             miso,
    input logic             cmd_valid,
    input logic             rd_req,
    input sprog_state_e     state,
    input logic [IDX_W-1:0] byte_idx
);
    // R1 and R8: hold empties the framing and the lock
    a_r1_hold_clears: assert property (@(posedge clk) disable iff (!rst_n)
        hold_s |=> (state == ST_HOLD && byte_idx == '0 && !cmd_valid && !rd_req && !miso));

    // R3: MISO moves only after a falling edge
    a_r3_miso_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (!sck_fall && !hold_s) |=> $stable(miso));

    // R2: byte position advances only on a rising edge
    a_r2_byte_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (!sck_rise && !hold_s) |=> $stable(byte_idx));

    // R5 and R6: commands leave only when enabled
    a_r6_valid_active: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> state == ST_ACTIVE);

    // R6: strobe lasts one cycle
    a_r6_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    // R7: read requests only when enabled
    a_r7_rdreq_active: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> state == ST_ACTIVE);

endmodule

bind sprog_if sprog_chk #(.IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .hold_s(hold_s),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .miso(miso),
    .cmd_valid(cmd_valid), .rd_req(rd_req),
    .state(state), .byte_idx(byte_idx)
);

// File: tb/sprog_if_tb.sv
module sprog_if_tb;
    localparam int HP = 6;   // clocks per SCK phase

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       prog_hold = 1'b1;
    logic       sck = 1'b0;
    logic       mosi = 1'b0;
    logic       miso, rd_req, cmd_valid;
    logic [7:0] rd_data, cmd_op, cmd_addr_hi, cmd_addr_lo, cmd_data;

    int checks = 0;
    int errors = 0;
    bit model_en = 1'b0;
    logic [31:0] exp_q [$];

    always #4 clk = ~clk;

    function automatic logic [7:0] rd_model(input logic [7:0] op, hi, lo);
        return op ^ {hi[3:0], hi[7:4]} ^ ~lo;
    endfunction

    assign rd_data = rd_model(cmd_op, cmd_addr_hi, cmd_addr_lo);

    sprog_if u_dut (
        .clk(clk), .rst_n(rst_n), .prog_hold(prog_hold),
        .sck(sck), .mosi(mosi), .miso(miso),
        .rd_data(rd_data), .rd_req(rd_req), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_addr_hi(cmd_addr_hi),
        .cmd_addr_lo(cmd_addr_lo), .cmd_data(cmd_data)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            mosi = tx[i];
            repeat (HP) @(negedge clk);
            rx[i] = miso;
            sck = 1'b1;
            repeat (HP) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    // driver: predicts MISO per byte and queues the expected command
    task automatic frame(input logic [7:0] b0, b1, b2, b3);
        logic [7:0] r0, r1, r2, r3, e3;
        e3 = model_en ? rd_model(b0, b1, b2) : b2;
        if (model_en) exp_q.push_back({b0, b1, b2, b3});
        xfer(b0, r0);
        xfer(b1, r1);
        xfer(b2, r2);
        xfer(b3, r3);
        check("R3 byte0 miso zero", {24'd0, r0}, 32'd0);
        check("R4 byte1 echo", {24'd0, r1}, {24'd0, b0});
        check("R4 byte2 echo", {24'd0, r2}, {24'd0, b1});
        check(model_en ? "R7 byte3 read value" : "R4 byte3 echo", {24'd0, r3}, {24'd0, e3});
        if (!model_en && b0 == 8'hAC && b1 == 8'h53) model_en = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic hold_pulse();
        prog_hold = 1'b1;
        repeat (6) @(negedge clk);
        check("R1 miso low in hold", {31'd0, miso}, 32'd0);
        prog_hold = 1'b0;
        model_en = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    // monitor: pops the scoreboard on every strobe
    always @(negedge clk) begin
        if (rst_n && cmd_valid === 1'b1) begin
            if (exp_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R5 unexpected command: got %0h expected none",
                         {cmd_op, cmd_addr_hi, cmd_addr_lo, cmd_data});
            end else begin
                check("R2/R6 command fields",
                      {cmd_op, cmd_addr_hi, cmd_addr_lo, cmd_data}, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] junk;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R1 reset miso", {31'd0, miso}, 32'd0);
        check("R1 reset cmd_valid", {31'd0, cmd_valid}, 32'd0);
        prog_hold = 1'b0;
        repeat (10) @(negedge clk);

        // R5: locked frames, including a near-miss enable
        frame(8'h30, 8'h00, 8'h01, 8'h00);
        frame(8'hAC, 8'h52, 8'h00, 8'h00);
        frame(8'h20, 8'h12, 8'h34, 8'h00);
        // enable, then active traffic (R6, R7)
        frame(8'hAC, 8'h53, 8'h00, 8'h00);
        frame(8'h20, 8'h12, 8'h34, 8'h00);
        frame(8'h40, 8'h0A, 8'h5C, 8'hA5);
        frame(8'hC0, 8'h01, 8'hFF, 8'h7E);
        frame(8'hAC, 8'h53, 8'h9B, 8'h18);

        // R8: hold two bytes into a frame
        xfer(8'h28, junk);
        xfer(8'h3C, junk);
        hold_pulse();
        frame(8'h28, 8'h3C, 8'h11, 8'h00);   // locked again: dropped
        frame(8'hAC, 8'h53, 8'h11, 8'h22);   // realigned enable
        frame(8'h48, 8'h07, 8'hE1, 8'h99);

        repeat (20) @(negedge clk);
        check("R6 all commands delivered", exp_q.size(), 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule